// File: doc/BRIEF.md
# Issue-Stage Hazard Interlock

This block sits at the single issue point of an in-order pipeline and decides, every cycle, whether the decoded instruction waiting there may enter execute. It checks read-after-write dependencies against a per-register countdown scoreboard. It checks structural availability of the partly pipelined divide and square-root units against per-unit repeat counters. It also honours a back-pressure stall from the memory and write-back stages and a squash request from branch resolution. For each source operand it reports whether the value must be taken from the execute bypass or from the register file.

Every instruction is assumed to read both source fields. An unused source is encoded as register 0. Each operation class has its own result latency. A granted writer loads its destination counter with that latency, and the counter counts down on every cycle that is not frozen by the memory stall. A reader may go when the counter is zero (register file) or one (bypass). When a mispredicted branch is resolved, the reservations made by the instructions issued in the last `FLUSH_DEPTH` issue cycles are withdrawn, while older reservations stay.

Top module: `issue_interlock`

## Requirements
- R1: After reset, with valid low, issue, stall and flush outputs are all low. The first valid instruction is granted in its own cycle with both forwarding selects 0.
- R2: Operation class encoding and latency are 0 integer (1), 1 add (3), 2 multiply (4), 3 divide (16) and 4 square root (21); codes 5 to 7 act as integer. A reader of a register written by class latency L, presented every cycle, is granted exactly L cycles after the producer's grant.
- R3: A reader directly following a one-cycle producer of its source is granted with no stall, and its forwarding select is 1 (1 = bypass from the end of execute, 0 = register file).
- R4: At the grant cycle of R2 the forwarding select of the dependent source is 1. One cycle later the same source reads with select 0.
- R5: Independent add and multiply instructions are granted on consecutive cycles.
- R6: After a divide is granted, another divide is refused until 5 cycles after it. Instructions of other classes are not held back by the divide unit.
- R7: After a square root is granted, another square root is refused until 7 cycles after it.
- R8: While the memory stall input is high, nothing is granted, stall is high for a valid instruction, and neither register countdowns nor repeat counters advance.
- R9: With flush high, nothing is granted and the flush output is high for a valid instruction. Register and unit reservations made in the last 2 issue cycles are cleared, and older reservations are kept.
- R10: Register 0 never causes a dependency. An instruction with destination 0 or with write enable low reserves nothing.
- R11: When a register is written again while an older write is pending, the younger write's latency decides when readers may go.
- R12: Stall is high exactly when valid is high, flush is low and no grant is given; stall and grant are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is waiting at issue |
| op_i | input | 3 | Operation class (R2 encoding) |
| rs1_i | input | $clog2(NREG) | First source register |
| rs2_i | input | $clog2(NREG) | Second source register |
| rd_i | input | $clog2(NREG) | Destination register |
| wr_en_i | input | 1 | Instruction writes its destination |
| flush_i | input | 1 | Squash request from branch resolution |
| mem_stall_i | input | 1 | Back-pressure from memory / write-back |
| issue_o | output | 1 | Instruction enters execute this cycle |
| stall_o | output | 1 | Instruction held at issue |
| fwd1_o | output | 1 | First source taken from bypass |
| fwd2_o | output | 1 | Second source taken from bypass |
| flush_o | output | 1 | Instruction at issue is squashed |

## Verification
Each operation class is swept as a producer, with a reader presented every cycle afterwards and the dependency placed alternately on the first and second source. The measured grant distance then separates the five latencies and catches off-by-one errors in the counter load or in the bypass window. Back-to-back same-class attempts on the divide and square-root units measure each repeat interval, and interleaved integer instructions show that the unit block applies to its own class only. Runs frozen by the memory stall show that countdowns pause rather than drain. A flush placed two cycles after a short-latency producer and one cycle after a square root, with a long divide reservation older than the window, separates withdrawn reservations from kept ones.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_INT  = 3'd0,
    OPC_FADD = 3'd1,
    OPC_FMUL = 3'd2,
    OPC_DIV  = 3'd3,
    OPC_SQRT = 3'd4
  } opc_e;

  localparam int NUM_UNITS = 2;
endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int NREG        = 32,
  parameter int CNT_W       = 6,
  parameter int FLUSH_DEPTH = 2,
  localparam int IDX_W      = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             flush_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [CNT_W-1:0] set_lat_i,
  input  logic [IDX_W-1:0] q1_idx_i,
  input  logic [IDX_W-1:0] q2_idx_i,
  output logic             rdy1_o,
  output logic             rdy2_o,
  output logic             fwd1_o,
  output logic             fwd2_o
);
  localparam logic [CNT_W-1:0] FD  = CNT_W'(FLUSH_DEPTH);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q [NREG];
  logic [CNT_W-1:0] lat_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign cnt_q[g] = '0;
      assign lat_q[g] = '0;
    end else begin : g_live
      logic hit;
      assign hit = set_i && (set_idx_i == IDX_W'(g));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q[g] <= '0;
          lat_q[g] <= '0;
        end else if (hit) begin
          cnt_q[g] <= set_lat_i;
          lat_q[g] <= set_lat_i;
        end else if (flush_i && cnt_q[g] != '0 && (lat_q[g] - cnt_q[g]) < FD) begin
          cnt_q[g] <= '0;  // reservation younger than the branch
        end else if (adv_i && cnt_q[g] != '0) begin
          cnt_q[g] <= cnt_q[g] - ONE;
        end
      end

      // R8
      frozen_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !flush_i && !hit) |=> $stable(cnt_q[g]));
    end
  end

  assign rdy1_o = (cnt_q[q1_idx_i] == '0) || (cnt_q[q1_idx_i] == ONE);
  assign rdy2_o = (cnt_q[q2_idx_i] == '0) || (cnt_q[q2_idx_i] == ONE);
  assign fwd1_o = (cnt_q[q1_idx_i] == ONE);
  assign fwd2_o = (cnt_q[q2_idx_i] == ONE);
endmodule

// File: rtl/hz_repeat.sv
module hz_repeat #(
  parameter int II          = 5,
  parameter int CNT_W       = 6,
  parameter int FLUSH_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic flush_i,
  input  logic load_i,
  output logic busy_o
);
  localparam logic [CNT_W-1:0] LOADV = CNT_W'(II - 1);
  localparam logic [CNT_W-1:0] FD    = CNT_W'(FLUSH_DEPTH);

  logic [CNT_W-1:0] rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             rep_q <= '0;
    else if (load_i)                                         rep_q <= LOADV;
    else if (flush_i && rep_q != '0 && (LOADV - rep_q) < FD) rep_q <= '0;
    else if (adv_i && rep_q != '0)                           rep_q <= rep_q - CNT_W'(1);
  end

  assign busy_o = (rep_q != '0);

  // R6 R7
  unit_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);

  // R8
  frozen_rep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !flush_i && !load_i) |=> $stable(rep_q));
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock #(
  parameter int NREG        = 32,
  parameter int LAT_FADD    = 3,
  parameter int LAT_FMUL    = 4,
  parameter int LAT_DIV     = 16,
  parameter int II_DIV      = 5,
  parameter int LAT_SQRT    = 21,
  parameter int II_SQRT     = 7,
  parameter int FLUSH_DEPTH = 2,
  localparam int IDX_W      = $clog2(NREG),
  localparam int CNT_W      = $clog2(LAT_FADD + LAT_FMUL + LAT_DIV + LAT_SQRT + II_DIV + II_SQRT + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [hz_pkg::OPC_W-1:0] op_i,
  input  logic [IDX_W-1:0]         rs1_i,
  input  logic [IDX_W-1:0]         rs2_i,
  input  logic [IDX_W-1:0]         rd_i,
  input  logic                     wr_en_i,
  input  logic                     flush_i,
  input  logic                     mem_stall_i,
  output logic                     issue_o,
  output logic                     stall_o,
  output logic                     fwd1_o,
  output logic                     fwd2_o,
  output logic                     flush_o
);
  import hz_pkg::*;

  localparam int                UNIT_II  [NUM_UNITS] = '{II_DIV, II_SQRT};
  localparam logic [OPC_W-1:0]  UNIT_OPC [NUM_UNITS] = '{OPC_DIV, OPC_SQRT};

  logic             adv, go, rdy1, rdy2, set_dst;
  logic [CNT_W-1:0] lat;
  logic [NUM_UNITS-1:0] unit_hit, unit_busy;

  always_comb begin
    case (op_i)
      OPC_FADD: lat = CNT_W'(LAT_FADD);
      OPC_FMUL: lat = CNT_W'(LAT_FMUL);
      OPC_DIV:  lat = CNT_W'(LAT_DIV);
      OPC_SQRT: lat = CNT_W'(LAT_SQRT);
      default:  lat = CNT_W'(1);
    endcase
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_hit[u] = (op_i == UNIT_OPC[u]);
    hz_repeat #(
      .II(UNIT_II[u]), .CNT_W(CNT_W), .FLUSH_DEPTH(FLUSH_DEPTH)
    ) u_rep (
      .clk_i, .rst_ni,
      .adv_i   (adv),
      .flush_i (flush_i),
      .load_i  (go && unit_hit[u]),
      .busy_o  (unit_busy[u])
    );
  end

  assign adv     = !mem_stall_i;
  assign go      = valid_i && !flush_i && adv && rdy1 && rdy2 && !(|(unit_hit & unit_busy));
  assign set_dst = go && wr_en_i && (rd_i != '0);

  hz_scoreboard #(
    .NREG(NREG), .CNT_W(CNT_W), .FLUSH_DEPTH(FLUSH_DEPTH)
  ) u_sb (
    .clk_i, .rst_ni,
    .adv_i     (adv),
    .flush_i   (flush_i),
    .set_i     (set_dst),
    .set_idx_i (rd_i),
    .set_lat_i (lat),
    .q1_idx_i  (rs1_i),
    .q2_idx_i  (rs2_i),
    .rdy1_o    (rdy1),
    .rdy2_o    (rdy2),
    .fwd1_o    (fwd1_o),
    .fwd2_o    (fwd2_o)
  );

  assign issue_o = go;
  assign stall_o = valid_i && !flush_i && !go;
  assign flush_o = valid_i && flush_i;

  // R8
  no_issue_in_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_i |-> !issue_o);

  // R9
  no_issue_in_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!issue_o && (flush_o == valid_i)));

  // R10
  zero_src_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !flush_i && !mem_stall_i && rs1_i == '0 && rs2_i == '0 && op_i == OPC_INT)
      |-> (issue_o && !fwd1_o && !fwd2_o));

  // R12
  grant_stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && stall_o));
endmodule

// File: tb/sim_issue_interlock.sv
module sim_issue_interlock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid, wr_en, flush, mstall;
  logic [2:0] op;
  logic [4:0] rs1, rs2, rd;
  logic       issue, stall, fwd1, fwd2, flush_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  issue_interlock u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .rs1_i(rs1), .rs2_i(rs2), .rd_i(rd), .wr_en_i(wr_en),
    .flush_i(flush), .mem_stall_i(mstall),
    .issue_o(issue), .stall_o(stall), .fwd1_o(fwd1), .fwd2_o(fwd2), .flush_o(flush_q)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, int o, int s1, int s2, int d, bit we, bit fl, bit ms);
    @(negedge clk);
    valid = v; op = 3'(o); rs1 = 5'(s1); rs2 = 5'(s2); rd = 5'(d);
    wr_en = we; flush = fl; mstall = ms;
    #1;
  endtask

  task automatic do_reset();
    valid = 0; op = 0; rs1 = 0; rs2 = 0; rd = 0; wr_en = 0; flush = 0; mstall = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int lat_tab [5];
    lat_tab = '{1, 3, 4, 16, 21};

    // R1 reset state and first grant
    do_reset();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 issue idle", int'(issue), 0);
    chk("R1 stall idle", int'(stall), 0);
    chk("R1 flush idle", int'(flush_q), 0);
    drive(1, 0, 3, 4, 2, 1, 0, 0);
    chk("R1 first grant", int'(issue), 1);
    chk("R1 fwd sel", int'(fwd1) + int'(fwd2), 0);

    // R2 R3 R4 latency sweep per class, dependency on rs1 or rs2 alternately
    for (int k = 0; k < 5; k++) begin
      int d;
      bit use2;
      use2 = (k % 2) == 1;
      do_reset();
      drive(1, k, 0, 0, 5, 1, 0, 0);
      chk("R2 producer grant", int'(issue), 1);
      d = 0;
      do begin
        d++;
        drive(1, 0, use2 ? 0 : 5, use2 ? 5 : 0, 0, 0, 0, 0);
        if (d == 1 && lat_tab[k] > 1) chk("R12 stall while waiting", int'(stall), 1);
      end while (!issue && d < 40);
      chk("R2 grant distance", d, lat_tab[k]);
      if (k == 0) chk("R3 bypass next cycle", int'(fwd1), 1);
      else        chk("R4 bypass at grant", int'(use2 ? fwd2 : fwd1), 1);
      drive(1, 0, use2 ? 0 : 5, use2 ? 5 : 0, 0, 0, 0, 0);
      chk("R4 regfile after", int'(use2 ? fwd2 : fwd1), 0);
      chk("R4 grant after", int'(issue), 1);
    end

    // R2 unused codes behave as integer
    do_reset();
    drive(1, 7, 0, 0, 6, 1, 0, 0);
    drive(1, 0, 6, 0, 0, 0, 0, 0);
    chk("R2 code 7 as integer", int'(issue) + int'(fwd1), 2);

    // R5 pipelined add / multiply
    do_reset();
    for (int i = 0; i < 4; i++) begin
      drive(1, (i % 2) + 1, 0, 0, i + 1, 1, 0, 0);
      chk("R5 back-to-back", int'(issue), 1);
    end

    // R6 R7 repeat intervals
    for (int u = 0; u < 2; u++) begin
      int d;
      int opc;
      opc = 3 + u;
      do_reset();
      drive(1, opc, 0, 0, 0, 0, 0, 0);
      drive(1, 0, 0, 0, 8, 1, 0, 0);
      chk(u == 0 ? "R6 other class free" : "R7 other class free", int'(issue), 1);
      d = 1;
      do begin
        d++;
        drive(1, opc, 0, 0, 0, 0, 0, 0);
      end while (!issue && d < 40);
      chk(u == 0 ? "R6 divide interval" : "R7 sqrt interval", d, u == 0 ? 5 : 7);
    end

    // R8 stall freezes countdowns
    begin
      int d;
      do_reset();
      drive(1, 2, 0, 0, 7, 1, 0, 0);
      for (int i = 0; i < 3; i++) begin
        drive(1, 0, 7, 0, 0, 0, 0, 1);
        chk("R8 no grant in stall", int'(issue), 0);
        chk("R8 stall out", int'(stall), 1);
      end
      d = 0;
      do begin
        d++;
        drive(1, 0, 7, 0, 0, 0, 0, 0);
      end while (!issue && d < 40);
      chk("R8 frozen countdown", d, 4);

      do_reset();
      drive(1, 3, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) drive(1, 3, 0, 0, 0, 0, 0, 1);
      d = 0;
      do begin
        d++;
        drive(1, 3, 0, 0, 0, 0, 0, 0);
      end while (!issue && d < 40);
      chk("R8 frozen repeat", d, 5);
    end

    // R9 flush window
    do_reset();
    drive(1, 3, 0, 0, 3, 1, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 4, 1, 0, 0);
    chk("R9 add grant", int'(issue), 1);
    drive(1, 4, 0, 0, 6, 1, 0, 0);
    chk("R9 sqrt grant", int'(issue), 1);
    drive(1, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 flush out", int'(flush_q), 1);
    chk("R9 no grant", int'(issue), 0);
    chk("R12 no stall in flush", int'(stall), 0);
    drive(1, 0, 4, 6, 0, 0, 0, 0);
    chk("R9 young cleared", int'(issue), 1);
    chk("R9 regfile sel", int'(fwd1) + int'(fwd2), 0);
    drive(1, 4, 0, 0, 0, 0, 0, 0);
    chk("R9 unit freed", int'(issue), 1);
    drive(1, 0, 3, 0, 0, 0, 0, 0);
    chk("R9 old kept", int'(issue), 0);

    // R10 register 0 and write enable
    do_reset();
    drive(1, 3, 0, 0, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R10 r0 free", int'(issue), 1);
    chk("R10 r0 sel", int'(fwd1) + int'(fwd2), 0);
    drive(1, 2, 0, 0, 5, 0, 0, 0);
    drive(1, 0, 5, 5, 0, 0, 0, 0);
    chk("R10 no write no dep", int'(issue), 1);
    chk("R10 no write sel", int'(fwd1) + int'(fwd2), 0);

    // R11 younger write wins
    do_reset();
    drive(1, 3, 0, 0, 9, 1, 0, 0);
    drive(1, 0, 0, 0, 9, 1, 0, 0);
    drive(1, 0, 9, 0, 0, 0, 0, 0);
    chk("R11 younger wins", int'(issue), 1);
    chk("R11 bypass", int'(fwd1), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule